// File: doc/BRIEF.md
# Auto-Detecting Serial Register Port

This block is a serial slave that gives a host read and write access to a small bank of 8-bit control registers. The host uses a chip select (active low), a serial clock and two data pins. Each time chip select goes active, the port looks at the level of the serial clock and picks one of two framings for that transaction. No strap pin or configuration bit selects the framing.

If the clock idles high, the port runs in shared-pin mode. One data pin carries both directions, bits travel least significant first, and the second data pin is not listened to. If the clock idles low, the port runs as an SPI mode 0 slave. The second data pin brings data in, the first drives data out, and bits travel most significant first.

Every transaction is a command byte followed by a data byte. All serial inputs pass through synchronizers on the system clock, and all edges of the serial clock are detected on the system clock.

Top module: `dual_mode_regport`

## Requirements
- R1: At every falling edge of `csN` the port latches the `sclk` level. A level of 1 selects shared-pin mode and a level of 0 selects SPI mode 0. The chosen mode does not change while the port stays selected.
- R2: A frame is 16 bits. The first byte is a command whose bit 7 is 1 for a read and 0 for a write, and whose bits 6:0 hold the register address. The second byte is the data. A write takes effect at the 16th rising `sclk` edge.
- R3: In SPI mode, `data2In` is sampled on rising `sclk` edges with the MSB first. `data1Out` changes only after falling edges and sends the read byte MSB first. `data1Oe` is high for the whole selected transaction.
- R4: In shared-pin mode, both bytes travel LSB first on `data1In`/`data1Out`, and the level on `data2In` has no effect on any register or output.
- R5: In shared-pin mode, `data1Oe` rises only during the data phase of a read. It goes high at the falling `sclk` edge that follows the 8th rising edge, and it stays low for the whole command phase and for every write.
- R6: `data1Oe` is low whenever `csN` has been high for three system clock cycles, and also after reset.
- R7: If `csN` rises before the 16th rising `sclk` edge, no register changes.
- R8: `NUM_REGS` registers reset to zero. A write to an address at or above `NUM_REGS` is dropped, and a read of such an address returns 0. Rising `sclk` edges after the 16th within one selection are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial inputs are sampled on it |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| data1In | input | 1 | Level on the shared data pin (host to port in shared-pin mode) |
| data2In | input | 1 | Host-to-port data in SPI mode; ignored in shared-pin mode |
| data1Out | output | 1 | Port-to-host data on the first data pin |
| data1Oe | output | 1 | Drive enable for the first data pin |

## Verification
The bench alternates the two framings from one transaction to the next. A port that remembered its last mode, or that sampled the clock level late, would swap the bit order and read back mirrored bytes. During shared-pin transfers the bench drives random noise on `data2In`, so an input mux that failed to disconnect that pin would corrupt the stored registers. Frames cut off at bit counts from 1 to 15 must leave the register bank untouched, while 17-bit frames must still write exactly once. A design that committed early, or that counted past 16, would change the value read back. The bench also checks the drive enable at every bit time in both modes, which catches a port that drives the shared pin during the command phase or a write and so fights the host.

// File: rtl/regport_pkg.sv
package regport_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = DATA_W - 1;
  localparam int CMD_BITS   = DATA_W;
  localparam int FRAME_BITS = 2 * DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int SEL_W      = $clog2(DATA_W);

  typedef enum logic {
    MODE_SPI    = 1'b0,
    MODE_SHARED = 1'b1
  } linkMode_e;

  typedef struct packed {
    logic             clearAll;
    logic             takeBit;
    logic             inBit;
    logic             latchCmd;
    logic             commitWrite;
    logic             driveNext;
    logic [SEL_W-1:0] bitIdx;
    linkMode_e        mode;
  } ctrlStrobe_t;
endpackage

// File: rtl/regport_ctrl.sv
module regport_ctrl
  import regport_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sclk,
  input  logic        data1In,
  input  logic        data2In,
  input  logic        cmdIsRead,
  output ctrlStrobe_t strobe,
  output logic        data1Oe,
  output logic        txnActive,
  output logic [CNT_W-1:0] bitCount
);
  logic [1:0] csSync, sclkSync, d1Sync, d2Sync;
  logic csS, sclkS, csPrev, sclkPrev;
  logic csFall, sclkRise, sclkFall;
  logic readDrive;
  linkMode_e mode;
  logic [CNT_W-1:0] bitCnt;

  // two-flop synchronizers for every asynchronous host signal
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync   <= 2'b11;
      sclkSync <= 2'b00;
      d1Sync   <= 2'b00;
      d2Sync   <= 2'b00;
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csSync   <= {csSync[0], csN};
      sclkSync <= {sclkSync[0], sclk};
      d1Sync   <= {d1Sync[0], data1In};
      d2Sync   <= {d2Sync[0], data2In};
      csPrev   <= csS;
      sclkPrev <= sclkS;
    end
  end

  assign csS   = csSync[1];
  assign sclkS = sclkSync[1];

  always_comb begin
    csFall   = csPrev & ~csS;
    sclkRise = txnActive & ~csS & ~sclkPrev & sclkS;
    sclkFall = txnActive & ~csS & sclkPrev & ~sclkS;

    strobe.clearAll    = csFall;
    strobe.takeBit     = sclkRise & (bitCnt < CNT_W'(FRAME_BITS));
    strobe.inBit       = (mode == MODE_SPI) ? d2Sync[1] : d1Sync[1];
    strobe.latchCmd    = strobe.takeBit & (bitCnt == CNT_W'(CMD_BITS - 1));
    strobe.commitWrite = strobe.takeBit & (bitCnt == CNT_W'(FRAME_BITS - 1)) & ~cmdIsRead;
    strobe.driveNext   = sclkFall & cmdIsRead & (bitCnt >= CNT_W'(CMD_BITS))
                       & (bitCnt < CNT_W'(FRAME_BITS));
    strobe.bitIdx      = bitCnt[SEL_W-1:0];
    strobe.mode        = mode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txnActive <= 1'b0;
      readDrive <= 1'b0;
      mode      <= MODE_SPI;
      bitCnt    <= '0;
    end else if (csFall) begin
      txnActive <= 1'b1;
      readDrive <= 1'b0;
      mode      <= linkMode_e'(sclkS);
      bitCnt    <= '0;
    end else if (csS) begin
      txnActive <= 1'b0;
      readDrive <= 1'b0;
    end else begin
      if (strobe.takeBit)   bitCnt    <= bitCnt + 1'b1;
      if (strobe.driveNext) readDrive <= 1'b1;
    end
  end

  assign data1Oe  = txnActive & ((mode == MODE_SPI) | readDrive);
  assign bitCount = bitCnt;
endmodule

// File: rtl/regport_dp.sv
module regport_dp
  import regport_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  output logic        cmdIsRead,
  output logic        data1Out
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [DATA_W-1:0] regBank [NUM_REGS];
  logic [DATA_W-1:0] shiftReg, nextShift, txByte, readVal;
  logic [ADDR_W-1:0] cmdAddr, rxAddr;
  logic [SEL_W-1:0]  outSel;

  assign rxAddr = nextShift[ADDR_W-1:0];

  always_comb begin
    if (strobe.mode == MODE_SPI) nextShift = {shiftReg[DATA_W-2:0], strobe.inBit};
    else                         nextShift = {strobe.inBit, shiftReg[DATA_W-1:1]};
    readVal = '0;
    if (int'(rxAddr) < NUM_REGS) readVal = regBank[rxAddr[IDX_W-1:0]];
    outSel = (strobe.mode == MODE_SPI) ? ~strobe.bitIdx : strobe.bitIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      txByte    <= '0;
      cmdAddr   <= '0;
      cmdIsRead <= 1'b0;
      data1Out  <= 1'b0;
    end else if (strobe.clearAll) begin
      shiftReg  <= '0;
      cmdIsRead <= 1'b0;
      data1Out  <= 1'b0;
    end else begin
      if (strobe.takeBit) shiftReg <= nextShift;
      if (strobe.latchCmd) begin
        cmdIsRead <= nextShift[DATA_W-1];
        cmdAddr   <= rxAddr;
        txByte    <= readVal;
      end
      if (strobe.driveNext) data1Out <= txByte[outSel];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++) regBank[r] <= '0;
    end else if (strobe.commitWrite) begin
      for (int r = 0; r < NUM_REGS; r++)
        if (cmdAddr == ADDR_W'(r)) regBank[r] <= nextShift;
    end
  end
endmodule

// File: rtl/dual_mode_regport.sv
module dual_mode_regport
  import regport_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic data1In,
  input  logic data2In,
  output logic data1Out,
  output logic data1Oe
);
  ctrlStrobe_t      strobe;
  logic             cmdIsRead;
  logic             txnActive;
  logic [CNT_W-1:0] bitCount;
  linkMode_e        curMode;

  regport_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk),
    .data1In(data1In), .data2In(data2In), .cmdIsRead(cmdIsRead),
    .strobe(strobe), .data1Oe(data1Oe), .txnActive(txnActive), .bitCount(bitCount)
  );

  regport_dp #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cmdIsRead(cmdIsRead), .data1Out(data1Out)
  );

  assign curMode = strobe.mode;
endmodule

// File: rtl/regport_checker.sv
module regport_checker
  import regport_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             sclk,
  input logic             data1Oe,
  input logic             inTxn,
  input linkMode_e        mode,
  input logic             cmdIsRead,
  input logic [CNT_W-1:0] bitCnt
);
  AST_MODE_FROM_CLOCK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inTxn) |-> (mode == linkMode_e'($past(sclk, 3))));  // R1

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (inTxn && $past(inTxn)) |-> $stable(mode));  // R1

  AST_SHARED_DRIVE_READ_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (data1Oe && mode == MODE_SHARED) |-> (cmdIsRead && bitCnt >= CNT_W'(CMD_BITS)));  // R5

  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(csN, 1) && $past(csN, 2) && $past(csN, 3)) |-> !data1Oe);  // R6
endmodule

bind dual_mode_regport regport_checker u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .data1Oe(data1Oe),
  .inTxn(txnActive), .mode(curMode), .cmdIsRead(cmdIsRead), .bitCnt(bitCount)
);

// File: tb/dual_mode_regport_test.sv
`timescale 1ns/1ps
module dual_mode_regport_test;
  localparam int NREG = 16;
  localparam int HALF = 8;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, data1In = 1'b0, data2In = 1'b0;
  logic data1Out, data1Oe;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] model [NREG];

  dual_mode_regport #(.NUM_REGS(NREG)) uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk),
    .data1In(data1In), .data2In(data2In), .data1Out(data1Out), .data1Oe(data1Oe)
  );

  always #2 clk = ~clk;

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [6:0] a);
    return (int'(a) < NREG) ? model[a[3:0]] : 8'h00;
  endfunction

  function automatic void expWrite(input logic [6:0] a, input logic [7:0] d, input int nBits);
    if (nBits >= 16 && int'(a) < NREG) model[a[3:0]] = d;
  endfunction

  // one transaction; nBits rising edges are given before release
  task automatic xfer(input bit shared, input bit rd, input logic [6:0] addr,
                      input logic [7:0] wdat, input int nBits,
                      output logic [7:0] rdat, output bit oeBad);
    logic [7:0] cmd = {rd, addr};
    bit b;
    rdat = '0; oeBad = 1'b0;
    sclk = shared; waitCyc(HALF);
    csN = 1'b0; waitCyc(HALF);
    for (int i = 0; i < nBits; i++) begin
      if (shared) begin
        sclk = 1'b0;
        b = (i < 8) ? cmd[i] : ((i < 16) ? wdat[i-8] : 1'b0);
        data1In = b; data2In = 1'($urandom);
        waitCyc(HALF);
        if (rd && i >= 8 && i < 16) begin
          rdat[i-8] = data1Out;
          if (data1Oe !== 1'b1) oeBad = 1'b1;
        end else if (data1Oe !== 1'b0) oeBad = 1'b1;
        sclk = 1'b1; waitCyc(HALF);
      end else begin
        b = (i < 8) ? cmd[7-i] : ((i < 16) ? wdat[15-i] : 1'b0);
        data2In = b; data1In = 1'($urandom);
        waitCyc(HALF);
        if (rd && i >= 8 && i < 16) rdat[15-i] = data1Out;
        if (data1Oe !== 1'b1) oeBad = 1'b1;
        sclk = 1'b1; waitCyc(HALF);
        sclk = 1'b0;
      end
    end
    waitCyc(HALF);
    csN = 1'b1;
    waitCyc(4);
    check(data1Oe === 1'b0, "R6 oe after release", int'(data1Oe), 0);
    waitCyc(HALF);
  endtask

  task automatic doRead(input bit shared, input logic [6:0] addr, input string req);
    logic [7:0] r; bit bad;
    xfer(shared, 1'b1, addr, 8'h00, 16, r, bad);
    check(r === expRead(addr), req, int'(r), int'(expRead(addr)));
    check(!bad, shared ? "R5 shared read drive window" : "R3 spi drive enable", int'(bad), 0);
  endtask

  task automatic doWrite(input bit shared, input logic [6:0] addr, input logic [7:0] d, input int nBits);
    logic [7:0] r; bit bad;
    xfer(shared, 1'b0, addr, d, nBits, r, bad);
    expWrite(addr, d, nBits);
    check(!bad, shared ? "R5 shared write no drive" : "R3 spi drive enable", int'(bad), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    waitCyc(5);
    check(data1Oe === 1'b0, "R6 oe in reset", int'(data1Oe), 0);
    rstN = 1'b1;
    waitCyc(5);
    check(data1Oe === 1'b0, "R6 oe after reset", int'(data1Oe), 0);

    doRead(1'b0, 7'd0, "R8 reset value spi");
    doRead(1'b1, 7'd15, "R8 reset value shared");
    doWrite(1'b0, 7'd3, 8'hA5, 16);
    doRead(1'b1, 7'd3, "R1 R4 spi write shared read");
    doWrite(1'b1, 7'd15, 8'h3C, 16);
    doRead(1'b0, 7'd15, "R2 R3 shared write spi read");
    doWrite(1'b0, 7'd16, 8'hFF, 16);
    doRead(1'b0, 7'd16, "R8 out of range read");
    doRead(1'b1, 7'd0, "R8 out of range write dropped");
    doWrite(1'b1, 7'd127, 8'h5A, 16);
    doRead(1'b0, 7'd0, "R8 top address write dropped");
    doWrite(1'b0, 7'd3, 8'h11, 12);
    doRead(1'b0, 7'd3, "R7 abort in data phase");
    doWrite(1'b1, 7'd3, 8'h22, 7);
    doRead(1'b1, 7'd3, "R7 abort in command phase");
    doWrite(1'b0, 7'd5, 8'h77, 17);
    doRead(1'b1, 7'd5, "R8 extra clock single write");
    doWrite(1'b1, 7'd6, 8'h81, 17);
    doRead(1'b0, 7'd6, "R8 extra clock shared");

    for (int t = 0; t < 70; t++) begin
      bit shared = 1'($urandom);
      logic [6:0] a = 7'($urandom_range(0, 19));
      if ($urandom_range(0, 2) == 0) begin
        doRead(shared, a, shared ? "R4 random shared read" : "R3 random spi read");
      end else begin
        int nb = ($urandom_range(0, 6) == 0) ? int'($urandom_range(1, 15)) : 16;
        doWrite(shared, a, 8'($urandom), nb);
        doRead(~shared, a, nb < 16 ? "R7 random abort" : "R2 random write readback");
      end
    end
    for (int i = 0; i < NREG; i++) doRead(i[0], 7'(i), "R2 final bank sweep");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule